// File: doc/BRIEF.md
# Access History Recorder with Per-PC Rows

This block watches the access stream of a data cache and keeps two histories of the cache lines touched. A global history logs every line that is not already in it, whatever instruction issued the access. A set of local history rows sits beside it. Each row is owned by one load PC, found by comparing the full PC against a tag on each row. When no tag matches, the least recently used row is taken over for the new PC.

Each access carries a virtual byte address, a PC and a hit/miss flag. The byte address is reduced to a line number by dropping the six offset bits. Each stored entry keeps the line number plus two side bits: the miss flag, and a flag that marks the start of a new 64 KB region. Both histories are exposed newest first. The local history shown is the one for the row used by the most recent access. A one-cycle strobe and the row index tell a downstream pattern detector when fresh history is available.

Top module: `access_history_tables`

## Requirements
- R1: The line number of an access is `acc_vaddr[31:6]` (26 bits). Entry k of a history sits at bits `[k*28 +: 28]` of its output vector. Entry 0 is the newest. An entry is packed as `{region_bit, miss_bit, line[25:0]}`.
- R2: An access whose line is not among the valid global entries is written at global index 0. Older entries each move up one index, and `glb_count` grows by one.
- R3: An access whose line already sits among the valid global entries leaves the global entries, their order and `glb_count` unchanged.
- R4: When the global history holds 128 entries, inserting a new line discards the oldest entry, and `glb_count` stays at 128.
- R5: An access whose PC equals the tag of a valid local row uses that row. From the next cycle, `loc_row` reports that row's index.
- R6: An access whose PC matches no valid tag claims the least recently used row and clears it. The row then holds only this access's line, so `loc_count` is 1. Right after reset, new PCs claim rows 31, 30, 29 and so on, in that order.
- R7: Within a local row, a line already present is not reinserted and the row's order is unchanged. A row keeps at most 24 entries, and the oldest entry is dropped on overflow.
- R8: Bit 26 of an entry is the `acc_miss` value of the access that inserted it.
- R9: Bit 27 of an entry is 1 in two cases: the history (or the freshly claimed row) was empty before the insert, or the line's region `line[25:10]` differs from the region of the previous newest entry. Otherwise the bit is 0.
- R10: `hist_upd` is high for exactly the cycle after an access that inserted into the global history or the local row, and is low otherwise. From the cycle after any access, `loc_row`, `loc_count` and `loc_hist` show the row that access used.
- R11: Reset empties both histories, invalidates every row tag and restores the row order of R6. `hist_upd` is 0.
- R12: A cycle with `acc_valid` low changes no history, no count and no row selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual byte address of the access |
| acc_pc | input | 32 | PC of the instruction making the access |
| acc_miss | input | 1 | 1 when the access missed in the cache |
| glb_hist | output | 3584 | Global history, 128 packed entries, newest at entry 0 |
| glb_count | output | 8 | Number of valid global entries |
| loc_hist | output | 672 | Local history of the selected row, 24 packed entries, newest at entry 0 |
| loc_count | output | 5 | Number of valid entries in the selected row |
| loc_row | output | 5 | Index of the row used by the most recent access |
| hist_upd | output | 1 | One-cycle strobe after an access that inserted something |

## Verification
Some states are hard to reach with short random runs. One is LRU eviction of a row that still holds entries while other rows have been touched since. Another is the global history sitting full while a line that was pushed out comes back as a fresh insert. The stimulus reaches these with directed phases. One phase streams 150 distinct lines under one PC, which fills the global history and that PC's row past capacity. Another cycles through 40 distinct PCs, more than the 32 rows, and then returns to the earliest ones so that they are claimed again from empty. Random traffic then mixes 36 PCs over a small line pool, so duplicates in either history and region changes occur often. A mid-run reset checks that old tags no longer hit.

// File: rtl/hist_pkg.sv
package hist_pkg;
   // side information packed above the line number of each entry
   localparam int INFO_W      = 2;
   localparam int INFO_MISS   = 0;
   localparam int INFO_REGION = 1;
endpackage

// File: rtl/hist_shift_buf.sv
module hist_shift_buf #(
   parameter int DEPTH        = 128,
   parameter int LINE_W       = 26,
   parameter int REGION_SHIFT = 10,
   localparam int CNT_W       = $clog2(DEPTH + 1),
   localparam int ENT_W       = LINE_W + hist_pkg::INFO_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   push,
   input  logic [LINE_W-1:0]      line,
   input  logic                   miss,
   output logic [DEPTH*ENT_W-1:0] hist,
   output logic [CNT_W-1:0]       count,
   output logic                   inserted
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("hist_shift_buf: DEPTH must be at least 2");
   end
   if (REGION_SHIFT >= LINE_W) begin : g_bad_region
      $error("hist_shift_buf: REGION_SHIFT must be below LINE_W");
   end

   logic [LINE_W-1:0]            line_q [DEPTH];
   logic [hist_pkg::INFO_W-1:0]  info_q [DEPTH];
   logic [CNT_W-1:0]             cnt_q;
   logic                         dup, region_new;

   always_comb begin
      dup = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CNT_W'(i) < cnt_q && line_q[i] == line) dup = 1'b1;
      end
      if (clr) dup = 1'b0;
   end

   assign region_new = clr || (cnt_q == '0) ||
                       (line[LINE_W-1:REGION_SHIFT] != line_q[0][LINE_W-1:REGION_SHIFT]);
   assign inserted   = push && !dup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            line_q[i] <= '0;
            info_q[i] <= '0;
         end
      end else if (inserted) begin
         line_q[0] <= line;
         info_q[0][hist_pkg::INFO_MISS]   <= miss;
         info_q[0][hist_pkg::INFO_REGION] <= region_new;
         for (int i = 1; i < DEPTH; i++) begin
            line_q[i] <= line_q[i-1];
            info_q[i] <= info_q[i-1];
         end
         if (clr)                       cnt_q <= CNT_W'(1);
         else if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
      end else if (clr) begin
         cnt_q <= '0;
      end
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_pack
      assign hist[k*ENT_W +: ENT_W] = {info_q[k], line_q[k]};
   end
   assign count = cnt_q;
endmodule

// File: rtl/pc_tag_lru.sv
module pc_tag_lru #(
   parameter int ROWS  = 32,
   parameter int PC_W  = 32,
   localparam int IDX_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] sel,
   output logic             alloc
);
   if (ROWS < 2) begin : g_bad_rows
      $error("pc_tag_lru: ROWS must be at least 2");
   end

   logic [PC_W-1:0]  tag_q [ROWS];
   logic [ROWS-1:0]  tv_q;
   logic [IDX_W-1:0] age_q [ROWS];
   logic             hit;
   logic [IDX_W-1:0] hit_idx, vic_idx;

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      vic_idx = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (tv_q[r] && tag_q[r] == pc) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(r);
         end
         if (age_q[r] == IDX_W'(ROWS - 1)) vic_idx = IDX_W'(r);
      end
   end

   assign sel   = hit ? hit_idx : vic_idx;
   assign alloc = !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tv_q <= '0;
         for (int r = 0; r < ROWS; r++) begin
            tag_q[r] <= '0;
            age_q[r] <= IDX_W'(r);
         end
      end else if (touch) begin
         for (int r = 0; r < ROWS; r++) begin
            if (IDX_W'(r) == sel)           age_q[r] <= '0;
            else if (age_q[r] < age_q[sel]) age_q[r] <= age_q[r] + IDX_W'(1);
         end
         if (alloc) begin
            tag_q[sel] <= pc;
            tv_q[sel]  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/access_history_tables.sv
module access_history_tables #(
   parameter int ADDR_W       = 32,
   parameter int PC_W         = 32,
   parameter int LINE_SHIFT   = 6,
   parameter int REGION_SHIFT = 10,
   parameter int GLB_DEPTH    = 128,
   parameter int LOC_DEPTH    = 24,
   parameter int LOC_ROWS     = 32
) (
   input  logic                                                         clk,
   input  logic                                                         rst_n,
   input  logic                                                         acc_valid,
   input  logic [ADDR_W-1:0]                                            acc_vaddr,
   input  logic [PC_W-1:0]                                              acc_pc,
   input  logic                                                         acc_miss,
   output logic [GLB_DEPTH*(ADDR_W-LINE_SHIFT+hist_pkg::INFO_W)-1:0]    glb_hist,
   output logic [$clog2(GLB_DEPTH+1)-1:0]                               glb_count,
   output logic [LOC_DEPTH*(ADDR_W-LINE_SHIFT+hist_pkg::INFO_W)-1:0]    loc_hist,
   output logic [$clog2(LOC_DEPTH+1)-1:0]                               loc_count,
   output logic [$clog2(LOC_ROWS)-1:0]                                  loc_row,
   output logic                                                         hist_upd
);
   localparam int LINE_W = ADDR_W - LINE_SHIFT;
   localparam int ENT_W  = LINE_W + hist_pkg::INFO_W;
   localparam int LCNT_W = $clog2(LOC_DEPTH + 1);
   localparam int IDX_W  = $clog2(LOC_ROWS);

   if (LINE_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("access_history_tables: LINE_SHIFT must be below ADDR_W");
   end

   logic [LINE_W-1:0] line;
   logic              g_ins, l_ins, alloc;
   logic [IDX_W-1:0]  sel;
   logic [LOC_ROWS-1:0] row_ins;
   logic [LOC_DEPTH*ENT_W-1:0] row_hist [LOC_ROWS];
   logic [LCNT_W-1:0]          row_cnt  [LOC_ROWS];
   logic              upd_q;
   logic [IDX_W-1:0]  row_q;

   assign line = acc_vaddr[ADDR_W-1:LINE_SHIFT];

   hist_shift_buf #(
      .DEPTH(GLB_DEPTH), .LINE_W(LINE_W), .REGION_SHIFT(REGION_SHIFT)
   ) glb_buf_i (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .push(acc_valid),
      .line(line), .miss(acc_miss),
      .hist(glb_hist), .count(glb_count), .inserted(g_ins)
   );

   pc_tag_lru #(.ROWS(LOC_ROWS), .PC_W(PC_W)) lru_i (
      .clk(clk), .rst_n(rst_n), .touch(acc_valid), .pc(acc_pc),
      .sel(sel), .alloc(alloc)
   );

   for (genvar r = 0; r < LOC_ROWS; r++) begin : g_row
      logic hit_me;
      assign hit_me = acc_valid && (sel == IDX_W'(r));
      hist_shift_buf #(
         .DEPTH(LOC_DEPTH), .LINE_W(LINE_W), .REGION_SHIFT(REGION_SHIFT)
      ) row_buf_i (
         .clk(clk), .rst_n(rst_n), .clr(hit_me && alloc), .push(hit_me),
         .line(line), .miss(acc_miss),
         .hist(row_hist[r]), .count(row_cnt[r]), .inserted(row_ins[r])
      );
   end

   assign l_ins = |row_ins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= 1'b0;
         row_q <= '0;
      end else begin
         upd_q <= acc_valid && (g_ins || l_ins);
         if (acc_valid) row_q <= sel;
      end
   end

   assign hist_upd  = upd_q;
   assign loc_row   = row_q;
   assign loc_hist  = row_hist[row_q];
   assign loc_count = row_cnt[row_q];
endmodule

// File: rtl/access_history_checker.sv
module access_history_checker #(
   parameter int ADDR_W     = 32,
   parameter int PC_W       = 32,
   parameter int LINE_SHIFT = 6,
   parameter int GLB_DEPTH  = 128,
   parameter int LOC_DEPTH  = 24,
   parameter int LOC_ROWS   = 32
) (
   input logic                                                       clk,
   input logic                                                       rst_n,
   input logic                                                       acc_valid,
   input logic [ADDR_W-1:0]                                          acc_vaddr,
   input logic [PC_W-1:0]                                            acc_pc,
   input logic                                                       acc_miss,
   input logic [GLB_DEPTH*(ADDR_W-LINE_SHIFT+hist_pkg::INFO_W)-1:0]  glb_hist,
   input logic [$clog2(GLB_DEPTH+1)-1:0]                             glb_count,
   input logic [LOC_DEPTH*(ADDR_W-LINE_SHIFT+hist_pkg::INFO_W)-1:0]  loc_hist,
   input logic [$clog2(LOC_DEPTH+1)-1:0]                             loc_count,
   input logic [$clog2(LOC_ROWS)-1:0]                                loc_row,
   input logic                                                       hist_upd
);
   localparam int LINE_W = ADDR_W - LINE_SHIFT;

   a_r4_glb_bound: assert property (@(posedge clk) disable iff (!rst_n)
      glb_count <= GLB_DEPTH);

   a_r7_loc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      loc_count <= LOC_DEPTH);

   a_r2_glb_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (glb_count == $past(glb_count)) || (glb_count == $past(glb_count) + 1));

   a_r2_newest_line: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_count != $past(glb_count)) |->
         hist_upd && (glb_hist[LINE_W-1:0] == $past(acc_vaddr[ADDR_W-1:LINE_SHIFT])));

   a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(glb_count) && $stable(loc_count) && $stable(loc_row) && !hist_upd);

   a_r10_upd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      hist_upd |-> $past(acc_valid));

   a_r6_loc_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> loc_count != '0);
endmodule

bind access_history_tables access_history_checker #(
   .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_SHIFT(LINE_SHIFT),
   .GLB_DEPTH(GLB_DEPTH), .LOC_DEPTH(LOC_DEPTH), .LOC_ROWS(LOC_ROWS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
   .acc_pc(acc_pc), .acc_miss(acc_miss), .glb_hist(glb_hist),
   .glb_count(glb_count), .loc_hist(loc_hist), .loc_count(loc_count),
   .loc_row(loc_row), .hist_upd(hist_upd)
);

// File: tb/access_history_tables_tb_top.sv
module access_history_tables_tb_top;
   localparam int GD = 128;
   localparam int LD = 24;
   localparam int NR = 32;
   localparam int EW = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic [31:0] acc_vaddr = '0;
   logic [31:0] acc_pc = '0;
   logic acc_miss = 1'b0;
   logic [GD*EW-1:0] glb_hist;
   logic [7:0] glb_count;
   logic [LD*EW-1:0] loc_hist;
   logic [4:0] loc_count;
   logic [4:0] loc_row;
   logic hist_upd;

   always #4 clk = ~clk;

   access_history_tables dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
      .acc_pc(acc_pc), .acc_miss(acc_miss), .glb_hist(glb_hist),
      .glb_count(glb_count), .loc_hist(loc_hist), .loc_count(loc_count),
      .loc_row(loc_row), .hist_upd(hist_upd)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   logic [EW-1:0] g_m [GD];
   int            g_n;
   logic [31:0]   t_pc [NR];
   bit            t_v  [NR];
   int            t_st [NR];
   logic [EW-1:0] l_m [NR][LD];
   int            l_n [NR];
   int            now_st;
   bit            exp_upd;
   int            exp_row;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      g_n = 0;
      now_st = 0;
      for (int r = 0; r < NR; r++) begin
         t_v[r] = 1'b0;
         t_pc[r] = '0;
         t_st[r] = -1 - r;
         l_n[r] = 0;
      end
   endtask

   task automatic model_access(input logic [31:0] va, input logic [31:0] pc, input bit miss);
      logic [25:0] ln;
      bit dup, rb, ins;
      int row, best;
      ln = va[31:6];
      ins = 1'b0;
      dup = 1'b0;
      for (int i = 0; i < g_n; i++) if (g_m[i][25:0] == ln) dup = 1'b1;
      if (!dup) begin
         rb = (g_n == 0) || (ln[25:10] != g_m[0][25:10]);
         for (int i = GD-1; i > 0; i--) g_m[i] = g_m[i-1];
         g_m[0] = {rb, miss, ln};
         if (g_n < GD) g_n++;
         ins = 1'b1;
      end
      row = -1;
      for (int r = 0; r < NR; r++) if (t_v[r] && t_pc[r] == pc) row = r;
      if (row < 0) begin
         best = 0;
         for (int r = 1; r < NR; r++) if (t_st[r] < t_st[best]) best = r;
         row = best;
         t_pc[row] = pc;
         t_v[row] = 1'b1;
         l_n[row] = 0;
      end
      t_st[row] = now_st;
      now_st++;
      dup = 1'b0;
      for (int i = 0; i < l_n[row]; i++) if (l_m[row][i][25:0] == ln) dup = 1'b1;
      if (!dup) begin
         rb = (l_n[row] == 0) || (ln[25:10] != l_m[row][0][25:10]);
         for (int i = LD-1; i > 0; i--) l_m[row][i] = l_m[row][i-1];
         l_m[row][0] = {rb, miss, ln};
         if (l_n[row] < LD) l_n[row]++;
         ins = 1'b1;
      end
      exp_upd = ins;
      exp_row = row;
   endtask

   task automatic compare_all(input string tag);
      int bad;
      bad = -1;
      check(hist_upd == exp_upd, "R10", {tag, " hist_upd"}, hist_upd, exp_upd);
      check(int'(loc_row) == exp_row, "R5 R6", {tag, " loc_row"}, loc_row, exp_row);
      check(int'(glb_count) == g_n, "R2 R3 R4", {tag, " glb_count"}, glb_count, g_n);
      check(int'(loc_count) == l_n[exp_row], "R6 R7", {tag, " loc_count"}, loc_count, l_n[exp_row]);
      for (int i = 0; i < g_n; i++)
         if (bad < 0 && glb_hist[i*EW +: EW] != g_m[i]) bad = i;
      check(bad < 0, "R1 R2 R8 R9", {tag, " glb entry"},
            (bad < 0) ? 0 : glb_hist[bad*EW +: EW], (bad < 0) ? 0 : g_m[bad]);
      bad = -1;
      for (int i = 0; i < l_n[exp_row]; i++)
         if (bad < 0 && loc_hist[i*EW +: EW] != l_m[exp_row][i]) bad = i;
      check(bad < 0, "R7 R8 R9", {tag, " loc entry"},
            (bad < 0) ? 0 : loc_hist[bad*EW +: EW], (bad < 0) ? 0 : l_m[exp_row][bad]);
   endtask

   // called at a falling edge; returns at the next falling edge with outputs checked
   task automatic access(input logic [31:0] va, input logic [31:0] pc, input bit miss,
                         input string tag);
      acc_valid = 1'b1;
      acc_vaddr = va;
      acc_pc = pc;
      acc_miss = miss;
      model_access(va, pc, miss);
      @(negedge clk);
      acc_valid = 1'b0;
      compare_all(tag);
   endtask

   task automatic do_reset();
      acc_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check(glb_count == 0, "R11", "glb_count after reset", glb_count, 0);
      check(loc_count == 0, "R11", "loc_count after reset", loc_count, 0);
      check(hist_upd == 1'b0, "R11", "hist_upd after reset", hist_upd, 0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_fail++;
      $display("FAIL R10 watchdog: actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] va, pc;
      logic [4:0] row_keep;
      logic [7:0] gc_keep;
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();

      // directed start
      access(32'h0001_0044, 32'h0000_4000, 1'b1, "first");
      check(glb_hist[EW-1:0] == {1'b1, 1'b1, 26'h000_0401}, "R1", "packing",
            glb_hist[EW-1:0], {1'b1, 1'b1, 26'h000_0401});
      check(glb_hist[26] == 1'b1, "R8", "miss bit", glb_hist[26], 1);
      check(glb_hist[27] == 1'b1, "R9", "region bit on empty", glb_hist[27], 1);
      check(loc_row == 5'd31, "R6", "first row", loc_row, 31);
      access(32'h0001_0040, 32'h0000_4000, 1'b0, "dup same pc");
      check(hist_upd == 1'b0, "R3", "duplicate no strobe", hist_upd, 0);
      check(loc_count == 5'd1, "R7", "duplicate local", loc_count, 1);
      access(32'h0001_0040, 32'h0000_4008, 1'b0, "dup new pc");
      check(loc_row == 5'd30, "R6", "second row", loc_row, 30);
      check(glb_count == 8'd1, "R3", "global dup count", glb_count, 1);
      access(32'h0001_0080, 32'h0000_4000, 1'b0, "same region");
      check(glb_hist[27] == 1'b0 && glb_hist[26] == 1'b0, "R9", "same region bits",
            glb_hist[27:26], 0);
      check(loc_row == 5'd31, "R5", "row reuse", loc_row, 31);
      access(32'h0005_0000, 32'h0000_4000, 1'b0, "new region");
      check(glb_hist[27] == 1'b1, "R9", "region change bit", glb_hist[27], 1);

      // idle cycles: nothing may move
      row_keep = loc_row;
      gc_keep = glb_count;
      acc_vaddr = 32'hDEAD_BEEF;
      acc_pc = 32'h1234_5678;
      repeat (3) @(negedge clk);
      check(glb_count == gc_keep && loc_row == row_keep && !hist_upd, "R12", "idle",
            {glb_count, loc_row, hist_upd}, {gc_keep, row_keep, 1'b0});

      // streaming: overflow of global and of one row
      for (int i = 0; i < 150; i++) begin
         va = (32'h0010_0000 + i) << 6;
         access(va, 32'h0000_9000, i[0], "stream R4");
      end
      check(glb_count == 8'd128, "R4", "global full", glb_count, 128);
      check(loc_count == 5'd24, "R7", "row full", loc_count, 24);
      access((32'h0010_0000 + 149) << 6, 32'h0000_9000, 1'b0, "dup when full");
      access(32'h0001_0040, 32'h0000_9000, 1'b0, "reinsert evicted line");

      // row pressure: 40 PCs, then revisit the first ones
      for (int p = 0; p < 40; p++) begin
         access((32'h0200_0000 + p) << 6, 32'h0001_0000 + p * 4, 1'b1, "evict R6");
         access((32'h0200_0100 + p) << 6, 32'h0001_0000 + p * 4, 1'b0, "evict R5");
      end
      for (int p = 0; p < 8; p++) begin
         access((32'h0200_0000 + p) << 6, 32'h0001_0000 + p * 4, 1'b0, "revisit R6");
         check(loc_count == 5'd1, "R6", "reclaimed row starts empty", loc_count, 1);
      end

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         va = {($urandom % 4) << 10 | ($urandom % 48), 6'(($urandom))};
         pc = 32'h0002_0000 + ($urandom % 36) * 4;
         access(va, pc, 1'($urandom), "random");
      end

      // reset in the middle: old tags must not hit
      do_reset();
      access(32'h0000_1000, 32'h0002_0000, 1'b0, "after reset R11");
      check(loc_row == 5'd31 && loc_count == 5'd1, "R11", "tags cleared",
            {loc_row, loc_count}, {5'd31, 5'd1});

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule